// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one eight-pin general-purpose I/O port behind a small register bus. Each pin has three controls. A direction bit selects output or input. An output bit sets the driven level when the pin is an output, and requests a pull-up when the pin is an input. A pin-level bit returns the synchronized pad level. The pad drivers sit outside the block. The block sends each pin an output-enable, a drive value and a pull-up request, and it takes back the raw pad level.

Two global controls act on every pin. The first is a pull-up kill that blocks every pull-up request. The second is a sleep gate that forces the sampled pad levels to zero, so that floating pads cannot disturb internal logic. Each pad level passes through a transparent-low latch and then a rising-edge flop before software can read it. Writing ones to the pin-level address toggles the matching output bits, which gives software an atomic toggle.

Top module: `gpio_port`

## Requirements
- R1: The register address is 2 bits wide. Address 1 is the direction register and address 2 is the output register. A write strobe stores `wdata` into the addressed register at the rising edge. A read strobe sampled at a rising edge loads that register's value into `rdata` at the same edge.
- R2: A direction bit of 1 sets that pin's `pad_oe` to 1, and a direction bit of 0 sets it to 0. The change appears right after the edge that stores the write.
- R3: For a pin whose `pad_oe` is 1, `pad_out` equals its output bit. For an input pin, `pad_out` is 0.
- R4: `pad_pu` of a pin is 1 only when the pin is an input, its output bit is 1, and `pud` is low. The pull-up is never requested on an output pin.
- R5: While `rst_n` is low, the direction and output registers and `rdata` are cleared at once, without waiting for a clock edge. All pins become inputs with no pull-up.
- R6: While `pud` is high, every `pad_pu` bit is 0. The stored output register is left unchanged and reads back as before.
- R7: A read of address 0 returns the synchronized pad levels. A pad level that is present before rising edge k is returned by a read whose strobe is sampled at edge k+1 or later. A read sampled at edge k itself still returns the earlier level.
- R8: While `sleep` is high, the synchronizer input is held at 0. A read of address 0 then returns 0 for every pin, whatever the pad levels are.
- R9: A write to address 0 inverts each output bit whose `wdata` bit is 1. Output bits whose `wdata` bit is 0 keep their value.
- R10: Address 3 is unused. A write to it changes no register, and a read of it returns 0.
- R11: `rdata` holds its last loaded value in every cycle that has no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 pin levels, 1 direction, 2 output, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pud | input | 1 | Global pull-up disable |
| sleep | input | 1 | Global sleep gate for pad sampling |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin drive level |
| pad_pu | output | 8 | Per-pin pull-up request |

## Verification
The results of a register write reach the pad outputs right after the edge that takes the write. The bench drives every input at a falling edge, so it checks the pad outputs at the next falling edge. Read data is loaded at the edge that samples the strobe. The scoreboard monitor therefore pops the expected byte at the falling edge that follows each strobed cycle. A pad level needs two rising edges before a read can return it: one edge for the synchronizer flop and one for the read register. The bench checks both the read that comes too early and the read that comes in time, and it holds sleep for two edges before it expects a zero read. The asynchronous reset is checked a few nanoseconds after `rst_n` falls, before any rising edge arrives.

// File: rtl/gpio_port_pkg.sv
// Package: shared register-select encoding for the GPIO port.
// Assumes a 2-bit register address; the pin-level select is address 0
// because the toggle-on-write behaviour is decoded at that address.
package gpio_port_pkg;

    localparam int unsigned GP_ADDR_W = 2;

    typedef enum logic [GP_ADDR_W-1:0] {
        SEL_LEVEL = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_DRIVE = 2'd2,
        SEL_NONE  = 2'd3
    } gp_sel_e;

endpackage

// File: rtl/gpio_port_regs.sv
// Direction and drive/pull-up registers of the port.
// Does: stores writes to the direction and drive registers, and toggles
// drive bits on writes to the pin-level address.
// Assumes: reset is active low and clears both registers asynchronously.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gp_sel_e          sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] drv_q
);

    // Direction register: a 1 makes the pin an output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_en && sel == SEL_DIR) begin
            dir_q <= wdata;
        end
    end

    // Drive register: plain write at its own address, XOR toggle at the level address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DRIVE: drv_q <= wdata;
                SEL_LEVEL: drv_q <= drv_q ^ wdata;
                default:   drv_q <= drv_q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_sync.sv
// Pad-level synchronizer: a transparent-low latch followed by a rising-edge flop.
// Does: samples the raw pad levels, gated to zero while sleep is high.
// Assumes: the latch holds during the high phase, so the flop always sees a
// stable value at the rising edge.
module gpio_port_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] level_q
);

    logic [WIDTH-1:0] gated;
    logic [WIDTH-1:0] lat_q;

    // Sleep gate: floating pads cannot reach the latch while sleep is high.
    assign gated = pad_in & ~{WIDTH{sleep}};

    // First stage: transparent while the clock is low.
    always_latch begin
        if (!clk) begin
            lat_q <= gated;
        end
    end

    // Second stage: capture the held latch value at the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= lat_q;
        end
    end

endmodule

// File: rtl/gpio_port_pad.sv
// Per-pin pad control.
// Does: derives the output enable, drive level and pull-up request from
// the direction and drive bits and the global pull-up kill.
// Assumes: the pad model drives pad_out only when pad_oe is high.
module gpio_port_pad #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] drv_q,
    input  logic             pud,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);

    // One identical slice for each pin.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pad_oe[i]  = dir_q[i];
        assign pad_out[i] = dir_q[i] & drv_q[i];
        assign pad_pu[i]  = ~dir_q[i] & drv_q[i] & ~pud;
    end

endmodule

// File: rtl/gpio_port.sv
// Top of the GPIO port.
// Does: holds the register bus decode, the registered read mux and the
// instances of the register, synchronizer and pad slices.
// Assumes: the read and write strobes last one cycle each and are driven
// synchronously to clk.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [GP_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]     wdata,
    output logic [WIDTH-1:0]     rdata,
    input  logic                 pud,
    input  logic                 sleep,
    input  logic [WIDTH-1:0]     pad_in,
    output logic [WIDTH-1:0]     pad_oe,
    output logic [WIDTH-1:0]     pad_out,
    output logic [WIDTH-1:0]     pad_pu
);

    gp_sel_e          sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] drv_q;
    logic [WIDTH-1:0] level_q;

    assign sel = gp_sel_e'(addr);

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wdata),
        .dir_q (dir_q),
        .drv_q (drv_q)
    );

    gpio_port_sync #(.WIDTH(WIDTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .pad_in  (pad_in),
        .level_q (level_q)
    );

    gpio_port_pad #(.WIDTH(WIDTH)) u_pad (
        .dir_q   (dir_q),
        .drv_q   (drv_q),
        .pud     (pud),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_pu  (pad_pu)
    );

    // Read register: loads the selected source on a read strobe, holds otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_LEVEL: rdata <= level_q;
                SEL_DIR:   rdata <= dir_q;
                SEL_DRIVE: rdata <= drv_q;
                default:   rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_chk.sv
// Checker for gpio_port: relates bus writes and reads to the pad outputs
// and read data over time. Attached to every gpio_port instance by bind.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [GP_ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]     wdata,
    input logic [WIDTH-1:0]     rdata,
    input logic                 pud,
    input logic                 sleep,
    input logic [WIDTH-1:0]     pad_oe,
    input logic [WIDTH-1:0]     pad_out,
    input logic [WIDTH-1:0]     pad_pu
);

    // R2: a direction write shows on the output enables after the edge.
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_DIR) |=> (pad_oe == $past(wdata)));

    // R3: a drive write shows on the output pins after the edge.
    p_drive_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_DRIVE) |=> (pad_out == ($past(wdata) & pad_oe)));

    // R4: no pull-up request on a pin that is driving.
    p_pu_not_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    // R6: the pull-up kill blocks every request.
    p_pud_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pud |-> (pad_pu == '0));

    // R8: after sleep has been held, a pin-level read returns zero.
    p_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep) && rd_en && addr == SEL_LEVEL) |=> (rdata == '0));

    // R9: a write at the level address toggles the driven levels of output pins.
    p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_LEVEL) |=>
            (pad_out == (($past(pad_out) ^ $past(wdata)) & pad_oe)));

    // R10: the unused address leaves the direction unchanged.
    p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_NONE) |=> $stable(pad_oe));

    // R11: read data holds without a strobe.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R5: under reset the pads stay tri-stated with no pull-up.
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r5: assert (pad_oe == '0 && pad_pu == '0 && rdata == '0);
        end
    end

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pud     (pud),
    .sleep   (sleep),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_pu  (pad_pu)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for gpio_port: the read task queues the expected bytes,
// and a monitor pops and compares them as read data appears.
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pud = 1'b0;
    logic       sleep = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pud(pud), .sleep(sleep), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // Records which rising edges sampled a read strobe.
    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compares read data against the queue one phase after the edge.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got=%h expected=%h", t, act, e);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5: pads tri-stated with no pull-up while reset is low.
        chk("R5 oe in reset", pad_oe, 8'h00);
        chk("R5 pu in reset", pad_pu, 8'h00);
        chk("R5 rdata in reset", rdata, 8'h00);
        rst_n = 1'b1;

        do_read(2'd1, 8'h00, "R5 dir after reset");
        do_write(2'd1, 8'hF0);
        chk("R2 oe", pad_oe, 8'hF0);
        do_read(2'd1, 8'hF0, "R1 dir readback");
        do_write(2'd2, 8'hAA);
        chk("R3 out", pad_out, 8'hA0);
        chk("R4 pu", pad_pu, 8'h0A);
        do_read(2'd2, 8'hAA, "R1 drive readback");

        // R6: pull-up kill.
        @(negedge clk); pud = 1'b1; #1;
        chk("R6 pu killed", pad_pu, 8'h00);
        do_read(2'd2, 8'hAA, "R6 drive kept");
        @(negedge clk); pud = 1'b0; #1;
        chk("R6 pu restored", pad_pu, 8'h0A);

        // R9: toggle through the level address.
        do_write(2'd0, 8'h3C);
        chk("R9 out after toggle", pad_out, 8'h90);
        do_read(2'd2, 8'h96, "R9 toggled drive");
        do_write(2'd0, 8'h00);
        do_read(2'd2, 8'h96, "R9 zero write no effect");

        // R10: unused address.
        do_write(2'd3, 8'hFF);
        do_read(2'd1, 8'hF0, "R10 dir unchanged");
        do_read(2'd2, 8'h96, "R10 drive unchanged");
        do_read(2'd3, 8'h00, "R10 read zero");

        // R11: read data holds while idle.
        do_read(2'd2, 8'h96, "R11 load");
        repeat (3) @(negedge clk);
        chk("R11 hold", rdata, 8'h96);

        // R7: pad change and read strobe in the same cycle return the old level.
        @(negedge clk);
        pad_in = 8'h5A; rd_en = 1'b1; addr = 2'd0;
        exp_q.push_back(8'h00); tag_q.push_back("R7 early read old level");
        @(negedge clk);
        rd_en = 1'b0;
        do_read(2'd0, 8'h5A, "R7 level after two edges");

        // R8: sleep gates the sampled levels.
        @(negedge clk); sleep = 1'b1;
        do_read(2'd0, 8'h00, "R8 sleep reads zero");
        @(negedge clk); sleep = 1'b0;
        @(negedge clk);
        do_read(2'd0, 8'h5A, "R8 level back after sleep");

        // R5: asynchronous reset, checked before any rising edge.
        @(negedge clk);
        #3 rst_n = 1'b0;
        #2;
        chk("R5 async oe", pad_oe, 8'h00);
        chk("R5 async out", pad_out, 8'h00);
        chk("R5 async pu", pad_pu, 8'h00);
        chk("R5 async rdata", rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        do_read(2'd2, 8'h00, "R5 drive cleared");
        do_read(2'd1, 8'h00, "R5 dir cleared");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule